// File: doc/BRIEF.md
# Strobed Pad Pull Resistor Controller

This block sets the internal pull resistor of each pad in a bank of general-purpose pins. The pull setting cannot be written per pin directly. Software first writes a pull code into one shared control word, waits a minimum setup time, and then sets bits in a pair of strobe words. Each pin whose strobe bit goes from 0 to 1 copies the shared code into its own latch. Clearing the strobe bit ends the capture.

The per-pin latches drive pull-up and pull-down enable outputs towards the pad ring. A setup timer restarts on every control write. A strobe edge that arrives before the timer has run out is dropped, and a sticky error flag is raised. A pin that holds its strobe bit high does not pick up later code changes. The pull state cannot be read back over the bus.

Top module: `pad_pull_ctrl`

## Requirements
- R1: After reset, every pull-up and pull-down enable is 0 and `setup_err` is 0.
- R2: A captured code of 1 drives the pin's pull-down enable to 1 and its pull-up enable to 0.
- R3: A captured code of 2 drives the pin's pull-up enable to 1 and its pull-down enable to 0.
- R4: A captured code of 0 clears both enables, which overrides any earlier setting.
- R5: The reserved code 3 is captured as code 0. A pin never has both enables at 1.
- R6: Pin p is strobed by bit p%32 of the strobe word at address `STROBE_BASE + 4*(p/32)`. Only pins whose strobe bit goes from 0 to 1 capture. All other pins keep their state.
- R7: A strobe bit that stays at 1 does not capture again when the code changes later.
- R8: Suppose a strobe edge is written N cycles after the last control write, or after reset is released. The edge captures only if N > `SETUP_CYCLES`. Otherwise the pin is left unchanged and `setup_err` becomes 1 in the next cycle.
- R9: Once `setup_err` is 1, it stays 1 until reset.
- R10: A write to `CTRL_ADDR` uses only bits [1:0] of the data as the code and ignores all higher bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | 32 | Write data |
| pull_up_en | output | NUM_PINS | Per-pin pull-up enable |
| pull_dn_en | output | NUM_PINS | Per-pin pull-down enable |
| setup_err | output | 1 | Sticky flag for a strobe edge issued too early |

## Verification
The bench builds the block with NUM_PINS = 54 and SETUP_CYCLES = 8. With 54 pins, the second strobe word is only partly populated, so the pin-to-word mapping is tested across the word boundary. The short setup window lets the bench place strobe writes exactly at N = 8, where they must be rejected, and at N = 9, where they must be accepted. Random mixes of control writes, strobe writes and idle gaps then land on both sides of this window many times in a short run.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;
   typedef enum logic [1:0] {
      PULL_OFF  = 2'd0,
      PULL_DOWN = 2'd1,
      PULL_UP   = 2'd2,
      PULL_RSVD = 2'd3
   } pull_code_e;

   // Reserved encodings fall back to no pull.
   function automatic pull_code_e sanitize(input logic [1:0] raw);
      return (raw == 2'd3) ? PULL_OFF : pull_code_e'(raw);
   endfunction
endpackage

// File: rtl/pull_setup_timer.sv
module pull_setup_timer #(
   parameter int SETUP_CYCLES = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic ready
);
   localparam int CW = $clog2(SETUP_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(SETUP_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (restart)      cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign ready = (cnt_q == LIMIT);

   // R8
   restart_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !ready);

   // R8
   ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !restart) |=> ready);
endmodule

// File: rtl/pull_pin_latch.sv
module pull_pin_latch
   import pad_pull_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe_rise,
   input  logic       setup_ok,
   input  logic [1:0] code,
   output logic       up_en,
   output logic       dn_en,
   output logic       too_early
);
   pull_code_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        state_q <= PULL_OFF;
      else if (strobe_rise && setup_ok)  state_q <= sanitize(code);
   end

   assign up_en     = (state_q == PULL_UP);
   assign dn_en     = (state_q == PULL_DOWN);
   assign too_early = strobe_rise && !setup_ok;

   // R5
   never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_en && dn_en));

   // R8
   early_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_rise && !setup_ok) |=> $stable(state_q));

   // R7
   no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_rise |=> $stable(state_q));
endmodule

// File: rtl/pad_pull_ctrl.sv
module pad_pull_ctrl #(
   parameter int          NUM_PINS     = 54,
   parameter int          SETUP_CYCLES = 150,
   parameter int          ADDR_W       = 8,
   parameter logic [7:0]  CTRL_ADDR    = 8'h94,
   parameter logic [7:0]  STROBE_BASE  = 8'h98
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [NUM_PINS-1:0] pull_up_en,
   output logic [NUM_PINS-1:0] pull_dn_en,
   output logic                setup_err
);
   localparam int WORD_W    = 32;
   localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

   if (NUM_PINS < 1 || NUM_PINS > 256) begin : g_bad_pins
      $error("NUM_PINS out of range");
   end
   if (SETUP_CYCLES < 1) begin : g_bad_setup
      $error("SETUP_CYCLES must be at least 1");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too narrow for register offsets");
   end

   logic                ctrl_wr;
   logic [1:0]          code_q;
   logic                setup_ok;
   logic [NUM_WORDS-1:0] word_wr;
   logic [NUM_PINS-1:0] strobe_q;
   logic [NUM_PINS-1:0] strobe_d;
   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] early;
   logic                err_q;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= 2'd0;
      else if (ctrl_wr) code_q <= bus_wdata[1:0];
   end

   pull_setup_timer #(.SETUP_CYCLES(SETUP_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctrl_wr),
      .ready   (setup_ok)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign word_wr[w] = bus_wr && (bus_addr == ADDR_W'(STROBE_BASE) + ADDR_W'(4 * w));
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign strobe_d[p] = word_wr[p / WORD_W] ? bus_wdata[p % WORD_W] : strobe_q[p];
      assign rise[p]     = strobe_d[p] && !strobe_q[p];

      pull_pin_latch u_latch (
         .clk         (clk),
         .rst_n       (rst_n),
         .strobe_rise (rise[p]),
         .setup_ok    (setup_ok),
         .code        (code_q),
         .up_en       (pull_up_en[p]),
         .dn_en       (pull_dn_en[p]),
         .too_early   (early[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= '0;
         err_q    <= 1'b0;
      end else begin
         strobe_q <= strobe_d;
         if (|early) err_q <= 1'b1;
      end
   end

   assign setup_err = err_q;

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      setup_err |=> setup_err);

   // R8
   early_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise && !setup_ok) |=> setup_err);

   // R6
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pull_up_en) && $stable(pull_dn_en)));
endmodule

// File: tb/pad_pull_ctrl_bench.sv
module pad_pull_ctrl_bench;
   localparam int NP    = 54;
   localparam int SETUP = 8;
   localparam logic [7:0] CTRL = 8'h94;
   localparam logic [7:0] SBASE = 8'h98;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [NP-1:0] pull_up_en, pull_dn_en;
   logic          setup_err;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [1:0]    m_state [NP];
   logic [NP-1:0] m_strobe;
   logic [1:0]    m_code;
   logic          m_err;
   int            since;

   always #10 clk = ~clk;

   pad_pull_ctrl #(.NUM_PINS(NP), .SETUP_CYCLES(SETUP)) u_pad_pull_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
      .setup_err(setup_err)
   );

   function automatic logic [NP-1:0] exp_up();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = (m_state[p] == 2'd2);
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_dn();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = (m_state[p] == 2'd1);
      return v;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (pull_up_en !== exp_up() || pull_dn_en !== exp_dn() || setup_err !== m_err) begin
         fails++;
         $display("FAIL %s: up=%h dn=%h err=%b expected up=%h dn=%h err=%b",
                  tag, pull_up_en, pull_dn_en, setup_err, exp_up(), exp_dn(), m_err);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         since++;
      end
   endtask

   // One write, one clock edge; model updated for that edge.
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      if (a == CTRL) begin
         m_code = d[1:0];
      end else begin
         for (int w = 0; w < 2; w++) begin
            if (a == SBASE + 8'(4 * w)) begin
               for (int b = 0; b < 32; b++) begin
                  int p = w * 32 + b;
                  if (p < NP) begin
                     if (d[b] && !m_strobe[p]) begin
                        if (since >= SETUP) m_state[p] = (m_code == 2'd3) ? 2'd0 : m_code;
                        else m_err = 1'b1;
                     end
                     m_strobe[p] = d[b];
                  end
               end
            end
         end
      end
      since = (a == CTRL) ? 0 : since + 1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   initial begin
      #3000000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_0042);
      for (int p = 0; p < NP; p++) m_state[p] = 2'd0;
      m_strobe = '0; m_code = 2'd0; m_err = 1'b0; since = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      since = 0;
      check("R1 reset");

      // R2: pull-down on pin 0 and pin 31
      wr(CTRL, 32'd1); idle(SETUP + 1);
      wr(SBASE, 32'h8000_0001);
      check("R2 pull-down capture");
      wr(SBASE, 32'h0);

      // R3 and R10: upper bits ignored, pull-up on pins 32 and 53
      wr(CTRL, 32'hFFFF_FFF6); idle(SETUP + 1);
      wr(SBASE + 8'd4, 32'h0020_0001);
      check("R3 pull-up capture, R10 upper bits ignored");
      check("R6 second word mapping");

      // R7: keep pin 32 high, change code, write same word again
      wr(CTRL, 32'd1); idle(SETUP + 1);
      wr(SBASE + 8'd4, 32'h0000_0001);
      check("R7 held strobe no recapture");
      wr(SBASE + 8'd4, 32'h0);

      // R4: code 0 clears pin 0
      wr(CTRL, 32'd0); idle(SETUP + 1);
      wr(SBASE, 32'h0000_0001);
      check("R4 clear pull");
      wr(SBASE, 32'h0);

      // R5: reserved code on pin 31 treated as none
      wr(CTRL, 32'd3); idle(SETUP + 1);
      wr(SBASE, 32'h8000_0000);
      check("R5 reserved code");
      wr(SBASE, 32'h0);

      // R8 boundary: N = SETUP rejected
      wr(CTRL, 32'd2); idle(SETUP - 1);
      wr(SBASE, 32'h0000_0010);
      check("R8 early strobe rejected");
      wr(SBASE, 32'h0);
      // R8 boundary: N = SETUP+1 accepted
      wr(CTRL, 32'd2); idle(SETUP);
      wr(SBASE, 32'h0000_0020);
      check("R8 strobe at limit accepted");
      wr(SBASE, 32'h0);
      idle(2);
      check("R9 error sticky");

      // Random mix
      for (int i = 0; i < 400; i++) begin
         int op = $urandom_range(0, 9);
         if (op < 2) wr(CTRL, $urandom());
         else if (op < 7) wr(SBASE + 8'(4 * $urandom_range(0, 1)),
                              $urandom() & $urandom() & $urandom());
         else idle($urandom_range(0, SETUP + 3));
         check("R6 random mix");
      end

      // Reset again: R1
      rst_n = 1'b0;
      for (int p = 0; p < NP; p++) m_state[p] = 2'd0;
      m_strobe = '0; m_code = 2'd0; m_err = 1'b0;
      @(negedge clk);
      rst_n = 1'b1; since = 0;
      check("R1 reset after activity");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule